// File: doc/BRIEF.md
# Register Window Validity Checker

This block keeps a per-window validity mask for a register-window machine and judges every window-moving operation against it. A save moves the current window pointer down by one, while a restore or a return-from-trap moves it up by one; both wrap modulo the implemented window count. Before the move is allowed, the bit of the destination window is looked up. A set bit means that window holds stale contents. The block then raises a window-overflow request for a save, or a window-underflow request for a restore or return-from-trap, and leaves the pointer where it was. A clear bit lets the move go ahead, and the block returns the new pointer together with a load strobe.

The mask is written and read through a simple port. Writes only take effect while the privilege input is high. Only as many mask bits as there are implemented windows hold state. All higher bits read as zero and ignore writes, so privileged code can learn the window count by writing all ones and reading the mask back. Saving window contents to memory, restoring them, and vectoring to a handler are done elsewhere; this block only produces the requests.

Top module: `regwin_guard`

## Requirements
- R1: While and right after reset, `mask_rdata` is zero and `ovf_req`, `unf_req` and `cwp_load` are low.
- R2: A write with `mask_we` and `priv` both high at a rising edge stores bits [NWIN-1:0] of `mask_wdata`, and `mask_rdata` shows them from that edge on.
- R3: Bits NWIN and above of `mask_rdata` are always 0. After all ones are written, the read value is 2^NWIN-1 (0x3F for NWIN=6).
- R4: A write with `priv` low leaves the mask unchanged, as observed on `mask_rdata`.
- R5: Operation codes on `op_code` are 0 = none, 1 = save, 2 = restore, 3 = return-from-trap. A save targets window (cwp-1) mod NWIN. If the mask bit of that window is 1, `ovf_req` is high for the cycle after the operation's edge, and `unf_req` stays low.
- R6: A restore or return-from-trap targets window (cwp+1) mod NWIN. If the mask bit of that window is 1, `unf_req` is high for the cycle after the operation's edge, and `ovf_req` stays low.
- R7: An operation whose target bit is 0 drives `cwp_load` high and `cwp_next` to the target window in the cycle after the operation's edge.
- R8: An operation that raises either request drives `cwp_load` low and `cwp_next` to the unchanged input pointer.
- R9: With `op_code` = 0, the next cycle has `cwp_load`, `ovf_req` and `unf_req` low and `cwp_next` equal to the sampled pointer.
- R10: An operation sampled at the same edge as an accepted mask write is judged against the mask value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 2 | Window operation: 0 none, 1 save, 2 restore, 3 return-from-trap |
| cwp | input | PTR_W | Current window pointer, assumed below NWIN |
| priv | input | 1 | Privileged mode; gates mask writes |
| mask_we | input | 1 | Mask write request |
| mask_wdata | input | 32 | Mask write value |
| mask_rdata | output | 32 | Mask read-back, unimplemented bits zero |
| ovf_req | output | 1 | Window-overflow request, one cycle |
| unf_req | output | 1 | Window-underflow request, one cycle |
| cwp_load | output | 1 | Move accepted; load `cwp_next` |
| cwp_next | output | PTR_W | Pointer after the judged operation |

## Verification
The hardest situation to reach is an operation at the wrap-around edge of a window count that is not a power of two. Examples are a save from window 0 that must land on window NWIN-1, or a restore from the top window that must land on 0, while only that single destination bit is set. The bench builds with six windows, places single-bit masks on exactly those destinations, and steps the pointer onto the edges. It also lines up a mask write and an operation on the same edge to check which mask value decides. Seeded random traffic then mixes privileged and unprivileged writes with operations at every pointer value.

// File: rtl/regwin_pkg.sv
// Package: shared operation encoding and widths for the register window checker.
// Assumes: a 32-bit mask port, wide enough for up to 32 windows.
package regwin_pkg;

    localparam int MASK_W = 32;

    typedef enum logic [1:0] {
        WOP_NONE    = 2'd0,
        WOP_SAVE    = 2'd1,
        WOP_RESTORE = 2'd2,
        WOP_RETURN  = 2'd3
    } win_op_e;

endpackage

// File: rtl/regwin_mask.sv
// Module: regwin_mask
// Holds the window invalid mask. Only the low NWIN bits keep state; the rest
// are forced to zero on every write, so they read as zero.
// Assumes: writes are accepted only when the privilege input is high.
module regwin_mask
    import regwin_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_priv,
    input  logic [MASK_W-1:0] wr_data,
    output logic [MASK_W-1:0] mask_q
);

    localparam logic [MASK_W-1:0] IMPL_MASK = (NWIN >= MASK_W) ? '1 :
                                              ((MASK_W'(1) << NWIN) - MASK_W'(1));

    logic wr_ok;

    // Purpose: qualify a write request with the privilege level.
    always_comb begin
        wr_ok = wr_en && wr_priv;
    end

    // Purpose: store the implemented mask bits; unimplemented bits stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_ok) begin
            mask_q <= wr_data & IMPL_MASK;
        end
    end

endmodule

// File: rtl/regwin_step.sv
// Module: regwin_step
// Works out the window an operation would move to: one down for save, one up
// for restore or return-from-trap, each wrapping modulo NWIN.
// Assumes: the incoming pointer is below NWIN.
module regwin_step
    import regwin_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int PTR_W = 3
) (
    input  win_op_e          op,
    input  logic [PTR_W-1:0] cwp,
    output logic [PTR_W-1:0] tgt,
    output logic             op_valid
);

    localparam logic [PTR_W-1:0] TOP_WIN = PTR_W'(NWIN - 1);

    logic [PTR_W-1:0] down_win;
    logic [PTR_W-1:0] up_win;

    // Purpose: neighbour windows with an explicit wrap at both ends.
    always_comb begin
        down_win = (cwp == '0)      ? TOP_WIN : cwp - PTR_W'(1);
        up_win   = (cwp == TOP_WIN) ? '0      : cwp + PTR_W'(1);
    end

    // Purpose: pick the destination that matches the operation.
    always_comb begin
        op_valid = 1'b1;
        unique case (op)
            WOP_SAVE:    tgt = down_win;
            WOP_RESTORE: tgt = up_win;
            WOP_RETURN:  tgt = up_win;
            default: begin
                tgt      = cwp;
                op_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/regwin_judge.sv
// Module: regwin_judge
// Looks up the destination window in the mask and registers the outcome:
// overflow or underflow request, or an accepted move with the new pointer.
// Assumes: the mask value given is the one before any write at this edge.
module regwin_judge
    import regwin_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  win_op_e           op,
    input  logic              op_valid,
    input  logic [PTR_W-1:0]  cwp,
    input  logic [PTR_W-1:0]  tgt,
    input  logic [MASK_W-1:0] mask_q,
    output logic              ovf_q,
    output logic              unf_q,
    output logic              load_q,
    output logic [PTR_W-1:0]  next_q
);

    logic hit;
    logic is_save;
    logic ovf_d;
    logic unf_d;
    logic load_d;
    logic [PTR_W-1:0] next_d;

    // Purpose: test the destination window's invalid bit.
    always_comb begin
        hit     = op_valid && mask_q[tgt];
        is_save = (op == WOP_SAVE);
    end

    // Purpose: decide the request kind and the resulting pointer.
    always_comb begin
        ovf_d  = hit && is_save;
        unf_d  = hit && !is_save;
        load_d = op_valid && !hit;
        next_d = load_d ? tgt : cwp;
    end

    // Purpose: register the verdict so it is stable for a full cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
            load_q <= 1'b0;
            next_q <= '0;
        end else begin
            ovf_q  <= ovf_d;
            unf_q  <= unf_d;
            load_q <= load_d;
            next_q <= next_d;
        end
    end

endmodule

// File: rtl/regwin_guard.sv
// Module: regwin_guard (top)
// Register window validity checker: privileged mask storage plus a one-cycle
// judgement of save, restore and return-from-trap against that mask.
// Assumes: 2 <= NWIN <= 32, cwp below NWIN, synchronous active-low reset.
module regwin_guard
    import regwin_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int PTR_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_code,
    input  logic [PTR_W-1:0]  cwp,
    input  logic              priv,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    output logic [MASK_W-1:0] mask_rdata,
    output logic              ovf_req,
    output logic              unf_req,
    output logic              cwp_load,
    output logic [PTR_W-1:0]  cwp_next
);

    win_op_e          op;
    logic [PTR_W-1:0] tgt;
    logic             op_valid;
    logic [MASK_W-1:0] mask_q;

    // Purpose: give the raw operation code its typed meaning.
    always_comb begin
        op = win_op_e'(op_code);
    end

    regwin_mask #(.NWIN(NWIN)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_we),
        .wr_priv (priv),
        .wr_data (mask_wdata),
        .mask_q  (mask_q)
    );

    regwin_step #(.NWIN(NWIN), .PTR_W(PTR_W)) u_step (
        .op       (op),
        .cwp      (cwp),
        .tgt      (tgt),
        .op_valid (op_valid)
    );

    regwin_judge #(.PTR_W(PTR_W)) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .op_valid (op_valid),
        .cwp      (cwp),
        .tgt      (tgt),
        .mask_q   (mask_q),
        .ovf_q    (ovf_req),
        .unf_q    (unf_req),
        .load_q   (cwp_load),
        .next_q   (cwp_next)
    );

    assign mask_rdata = mask_q;

endmodule

// File: rtl/regwin_guard_chk.sv
// Module: regwin_guard_chk
// Port-level properties of the window validity checker, bound to every
// instance of regwin_guard.
module regwin_guard_chk #(
    parameter int NWIN  = 8,
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op_code,
    input logic [PTR_W-1:0] cwp,
    input logic             priv,
    input logic             mask_we,
    input logic [31:0]      mask_rdata,
    input logic             ovf_req,
    input logic             unf_req,
    input logic             cwp_load,
    input logic [PTR_W-1:0] cwp_next
);

    localparam logic [31:0] IMPL = (NWIN >= 32) ? '1 : ((32'd1 << NWIN) - 32'd1);

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rdata & ~IMPL) == 32'd0);                                       // R3
    AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !priv) |=> $stable(mask_rdata));                          // R4
    AST_SAVE_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'd1) |=> !unf_req);                                      // R5
    AST_UP_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code[1]) |=> !ovf_req);                                           // R6
    AST_LOAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cwp_load |-> (int'(cwp_next) < NWIN));                                // R7
    AST_EXC_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != 2'd0) |=> ((ovf_req || unf_req) ? (!cwp_load && cwp_next == $past(cwp)) : cwp_load)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'd0) |=> (!cwp_load && !ovf_req && !unf_req && cwp_next == $past(cwp))); // R9

endmodule

bind regwin_guard regwin_guard_chk #(.NWIN(NWIN), .PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_code    (op_code),
    .cwp        (cwp),
    .priv       (priv),
    .mask_we    (mask_we),
    .mask_rdata (mask_rdata),
    .ovf_req    (ovf_req),
    .unf_req    (unf_req),
    .cwp_load   (cwp_load),
    .cwp_next   (cwp_next)
);

// File: tb/regwin_guard_tb.sv
module regwin_guard_tb;

    localparam int NWIN  = 6;
    localparam int PTR_W = 3;
    localparam logic [31:0] IMPL = (32'd1 << NWIN) - 32'd1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       op_code = 2'd0;
    logic [PTR_W-1:0] cwp = '0;
    logic             priv = 1'b0;
    logic             mask_we = 1'b0;
    logic [31:0]      mask_wdata = '0;
    logic [31:0]      mask_rdata;
    logic             ovf_req;
    logic             unf_req;
    logic             cwp_load;
    logic [PTR_W-1:0] cwp_next;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] wim_m = '0;

    always #2.5 clk = ~clk;

    regwin_guard #(.NWIN(NWIN), .PTR_W(PTR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .cwp(cwp), .priv(priv),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
        .ovf_req(ovf_req), .unf_req(unf_req), .cwp_load(cwp_load), .cwp_next(cwp_next)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle of stimulus, predict from the shadow mask, check after the edge.
    task automatic step(input logic [1:0] op, input int c, input logic p,
                        input logic we, input logic [31:0] wd, input string tag);
        int tgt;
        logic hit, e_ovf, e_unf, e_load;
        int e_next;
        @(negedge clk);
        op_code = op; cwp = PTR_W'(c); priv = p; mask_we = we; mask_wdata = wd;
        if (op == 2'd1) tgt = (c == 0) ? NWIN - 1 : c - 1;
        else            tgt = (c == NWIN - 1) ? 0 : c + 1;
        hit    = (op != 2'd0) && wim_m[tgt];   // R10: old mask decides
        e_ovf  = hit && (op == 2'd1);
        e_unf  = hit && (op != 2'd1);
        e_load = (op != 2'd0) && !hit;
        e_next = e_load ? tgt : c;
        if (we && p) wim_m = wd & IMPL;
        @(posedge clk); #1;
        chk({tag, " R5 ovf"},  32'(ovf_req),  32'(e_ovf));
        chk({tag, " R6 unf"},  32'(unf_req),  32'(e_unf));
        chk({tag, " R7 load"}, 32'(cwp_load), 32'(e_load));
        chk({tag, " R8 next"}, 32'(cwp_next), 32'(e_next));
        chk({tag, " R2 mask"}, mask_rdata,    wim_m);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset mask", mask_rdata, 32'd0);
        chk("R1 reset ovf",  32'(ovf_req),  32'd0);
        chk("R1 reset unf",  32'(unf_req),  32'd0);
        chk("R1 reset load", 32'(cwp_load), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after reset mask", mask_rdata, 32'd0);

        // R3: all-ones write reveals the window count
        step(2'd0, 0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R3 ones");
        chk("R3 readback", mask_rdata, 32'h0000_003F);
        // R4: unprivileged write ignored
        step(2'd0, 2, 1'b0, 1'b1, 32'h0, "R4 user");
        chk("R4 unchanged", mask_rdata, 32'h0000_003F);
        // R2: privileged pattern
        step(2'd0, 1, 1'b1, 1'b1, 32'hAAAA_AA15, "R2 pattern");
        chk("R2 readback", mask_rdata, 32'h0000_0015);
        // R5: save wraps from 0 to top window, which is the only set bit
        step(2'd0, 0, 1'b1, 1'b1, 32'h0000_0020, "R2 setup");
        step(2'd1, 0, 1'b0, 1'b0, 32'h0, "R5 wrap save");
        chk("R5 overflow at wrap", 32'(ovf_req), 32'd1);
        step(2'd1, 1, 1'b0, 1'b0, 32'h0, "R7 save ok");
        chk("R7 save to window 0", 32'(cwp_next), 32'd0);
        // R6: restore/return wrap from top to 0
        step(2'd0, 0, 1'b1, 1'b1, 32'h0000_0001, "R2 setup");
        step(2'd2, 5, 1'b0, 1'b0, 32'h0, "R6 wrap restore");
        chk("R6 underflow restore", 32'(unf_req), 32'd1);
        chk("R8 pointer kept", 32'(cwp_next), 32'd5);
        step(2'd3, 5, 1'b0, 1'b0, 32'h0, "R6 wrap return");
        chk("R6 underflow return", 32'(unf_req), 32'd1);
        step(2'd2, 0, 1'b0, 1'b0, 32'h0, "R7 restore ok");
        chk("R7 restore to 1", 32'(cwp_next), 32'd1);
        // R9: idle
        step(2'd0, 4, 1'b0, 1'b0, 32'h0, "R9 idle");
        chk("R9 no load", 32'(cwp_load), 32'd0);
        // R10: same-edge write uses old mask
        step(2'd0, 0, 1'b1, 1'b1, 32'h0, "R2 clear");
        step(2'd1, 3, 1'b1, 1'b1, 32'h0000_003F, "R10 collide");
        chk("R10 old mask decides", 32'(ovf_req), 32'd0);
        step(2'd1, 3, 1'b0, 1'b0, 32'h0, "R10 after");
        chk("R10 new mask now", 32'(ovf_req), 32'd1);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [1:0]  r_op = 2'($urandom_range(0, 3));
            int          r_c  = $urandom_range(0, NWIN - 1);
            logic        r_p  = 1'($urandom_range(0, 1));
            logic        r_we = ($urandom_range(0, 3) == 0);
            logic [31:0] r_wd = $urandom();
            step(r_op, r_c, r_p, r_we, r_wd, "rand");
        end

        @(negedge clk);
        op_code = 2'd0; mask_we = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule